// File: doc/BRIEF.md
# BT.656 Video Receive Decoder

This block takes a parallel BT.656-style video stream, 8 or 10 bits per sample with one sample per clock, and turns it into a qualified sample stream plus the current field and blanking flags. It watches for the timing-reference sequence: one all-ones word, two all-zeros words, then a protected status word. From the status word it takes the field (F), vertical-blanking (V) and horizontal (H) flags. A single flipped bit in that word is repaired. A word that cannot be repaired is dropped, and a sticky error flag is raised.

A capture-mode input selects which samples leave the block. The choices are the active picture only, the active part of vertical-blanking lines only, or every sample of the field. Timing-reference words never appear at the output. Two further options act on the selected samples. One drops every other sample, keeping either the even or the odd ones counted from the last status word. The other widens each sample to the output width by sign extension or by zero fill. The outputs are registered and follow the input sample by one clock.

Top module: `vid656_rx`

## Requirements
- R1: The word after the sequence all-ones, all-zeros, all-zeros is taken as the status word. Its top eight bits, from most significant down, are a fixed 1, F, V, H, P3, P2, P1, P0. The decoded flags appear on `fld`, `vblank` and `hblank` one clock after the status word is presented.
- R2: A status word with P3=V^H, P2=F^H, P1=F^V and P0=F^V^H loads its F, V and H unchanged. The flags change only when a status word is accepted.
- R3: A status word with any single one of F, V, H or P3..P0 inverted is repaired and loads the original flags, without raising the error flag. The fixed top bit is not examined.
- R4: Any other protection mismatch leaves the flags unchanged and sets `hdr_err`. That flag stays set until reset.
- R5: All-ones words, the two zero words of a timing-reference sequence and every status word never produce `out_valid`, in any mode.
- R6: With `cap_mode`=0 (active only), a sample is forwarded only while V=0 and H=0.
- R7: With `cap_mode`=1 (blanking only), a sample is forwarded only while V=1 and H=0.
- R8: With `cap_mode`=2 (whole field), every sample that is not a timing-reference word is forwarded. `out_valid` and `out_data` for a sample appear one clock after it is presented.
- R9: With `cap_mode`=3, or before the first accepted status word after reset, `out_valid` stays low.
- R10: With `drop_en`=1, the samples selected since the last accepted status word are numbered from 0. Only even-numbered ones (`keep_odd`=0) or only odd-numbered ones (`keep_odd`=1) are forwarded.
- R11: `out_data` is the sample widened to OUT_W bits. With `sign_ext`=1 the upper bits copy the sample's top bit; with `sign_ext`=0 they are zero.
- R12: During and right after reset, `out_valid`, `out_data`, the three flags and `hdr_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one input word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | PIX_W | Incoming video word |
| cap_mode | input | 2 | 0 active, 1 vertical blanking, 2 whole field, 3 off |
| drop_en | input | 1 | Enable alternate-sample dropping |
| keep_odd | input | 1 | When dropping, keep odd (1) or even (0) samples |
| sign_ext | input | 1 | Widen by sign extension (1) or zero fill (0) |
| out_data | output | OUT_W | Widened forwarded sample |
| out_valid | output | 1 | `out_data` holds a forwarded sample |
| fld | output | 1 | Field flag from the last accepted status word |
| vblank | output | 1 | Vertical-blanking flag from the last accepted status word |
| hblank | output | 1 | Horizontal flag (1 after end of active video) |
| hdr_err | output | 1 | Sticky uncorrectable status-word error |

## Verification
The assertions assume that the mode and option inputs are sampled on the same edge as the word they apply to. They also assume that ordinary picture samples never take the all-ones value, which the block treats as reserved. The stimulus drives every input on the falling edge and keeps all data samples away from the all-ones and all-zeros codes. Timing-reference sequences are sent only as whole groups, except for one deliberate lone all-ones word. Uncorrectable status words are sent only after a reset or at the end of a test, so the sticky flag cannot hide later results.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  typedef enum logic [1:0] {
    CAP_ACTIVE = 2'b00,
    CAP_VBLANK = 2'b01,
    CAP_FIELD  = 2'b10,
    CAP_OFF    = 2'b11
  } cap_mode_e;

  typedef enum logic [1:0] {
    TRS_IDLE = 2'b00,
    TRS_ONES = 2'b01,
    TRS_Z1   = 2'b10,
    TRS_Z2   = 2'b11
  } trs_state_e;

  // protection bits {P3,P2,P1,P0} for a given flag triple
  function automatic logic [3:0] prot_of(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid656_trs_track.sv
module vid656_trs_track
  import vid656_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] word,
  output logic             is_status,
  output logic             is_trs
);

  localparam logic [PIX_W-1:0] ALL_ONES = '1;
  localparam logic [PIX_W-1:0] ALL_ZERO = '0;

  trs_state_e st, st_nx;
  logic w_ones, w_zero;

  assign w_ones = (word == ALL_ONES);
  assign w_zero = (word == ALL_ZERO);

  always_comb begin
    st_nx = TRS_IDLE;
    unique case (st)
      TRS_IDLE: st_nx = w_ones ? TRS_ONES : TRS_IDLE;
      TRS_ONES: st_nx = w_ones ? TRS_ONES : (w_zero ? TRS_Z1 : TRS_IDLE);
      TRS_Z1:   st_nx = w_zero ? TRS_Z2 : (w_ones ? TRS_ONES : TRS_IDLE);
      TRS_Z2:   st_nx = TRS_IDLE;
      default:  st_nx = TRS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TRS_IDLE;
    else     st <= st_nx;
  end

  assign is_status = (st == TRS_Z2);
  assign is_trs    = is_status | w_ones |
                     (w_zero & ((st == TRS_ONES) | (st == TRS_Z1)));

  AST_STATUS_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_status |-> ($past(word) == ALL_ZERO)); // R1

endmodule

// File: rtl/vid656_status_dec.sv
module vid656_status_dec
  import vid656_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic [6:0] hdr,
  output logic       good_stb,
  output logic       locked,
  output logic       f_q,
  output logic       v_q,
  output logic       h_q,
  output logic       err_q
);

  logic       rf, rv, rh;
  logic [3:0] syn;
  logic       fix_f, fix_v, fix_h, bad;

  assign rf  = hdr[6];
  assign rv  = hdr[5];
  assign rh  = hdr[4];
  assign syn = hdr[3:0] ^ prot_of(rf, rv, rh);

  always_comb begin
    fix_f = 1'b0;
    fix_v = 1'b0;
    fix_h = 1'b0;
    bad   = 1'b0;
    unique case (syn)
      4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001: ; // clean or parity-bit hit
      4'b0111: fix_f = 1'b1;
      4'b1011: fix_v = 1'b1;
      4'b1101: fix_h = 1'b1;
      default: bad   = 1'b1;
    endcase
  end

  assign good_stb = stb & ~bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= 1'b0;
      v_q    <= 1'b0;
      h_q    <= 1'b0;
      locked <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (good_stb) begin
        f_q    <= rf ^ fix_f;
        v_q    <= rv ^ fix_v;
        h_q    <= rh ^ fix_h;
        locked <= 1'b1;
      end
      if (stb & bad) err_q <= 1'b1;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable({f_q, v_q, h_q})); // R2
  AST_BAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stb && !good_stb) |=> ($stable({f_q, v_q, h_q}) && err_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R9

endmodule

// File: rtl/vid656_sample_path.sv
module vid656_sample_path
  import vid656_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] word,
  input  logic             is_trs,
  input  logic             good_stb,
  input  logic             locked,
  input  logic             v_q,
  input  logic             h_q,
  input  cap_mode_e        mode,
  input  logic             drop_en,
  input  logic             keep_odd,
  input  logic             sign_ext,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid
);

  localparam int PAD = OUT_W - PIX_W;

  logic             in_region, cand, keep, phase;
  logic [OUT_W-1:0] wide;

  always_comb begin
    unique case (mode)
      CAP_ACTIVE: in_region = ~v_q & ~h_q;
      CAP_VBLANK: in_region =  v_q & ~h_q;
      CAP_FIELD:  in_region = 1'b1;
      default:    in_region = 1'b0;
    endcase
  end

  assign cand = locked & in_region & ~is_trs;
  assign keep = ~drop_en | (phase == keep_odd);

  generate
    if (PAD > 0) begin : g_widen
      assign wide = {{PAD{sign_ext & word[PIX_W-1]}}, word};
    end else begin : g_trunc
      assign wide = word[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (good_stb)  phase <= 1'b0;
      else if (cand) phase <= ~phase;
      out_valid <= cand & keep;
      if (cand & keep) out_data <= wide;
    end
  end

  AST_TRS_SILENT: assert property (@(posedge clk) disable iff (rst)
    is_trs |=> !out_valid); // R5
  AST_ACTIVE_WIN: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_ACTIVE && (v_q || h_q)) |=> !out_valid); // R6
  AST_VBLANK_WIN: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_VBLANK && (!v_q || h_q)) |=> !out_valid); // R7
  AST_FIELD_ALL: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_FIELD && locked && !is_trs && !drop_en) |=> out_valid); // R8
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_OFF || !locked) |=> !out_valid); // R9

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx
  import vid656_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [1:0]       cap_mode,
  input  logic             drop_en,
  input  logic             keep_odd,
  input  logic             sign_ext,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  output logic             fld,
  output logic             vblank,
  output logic             hblank,
  output logic             hdr_err
);

  logic is_status, is_trs, good_stb, locked;

  vid656_trs_track #(.PIX_W(PIX_W)) u_trs (
    .clk       (clk),
    .rst       (rst),
    .word      (pix_in),
    .is_status (is_status),
    .is_trs    (is_trs)
  );

  vid656_status_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .stb      (is_status),
    .hdr      (pix_in[PIX_W-2 -: 7]),
    .good_stb (good_stb),
    .locked   (locked),
    .f_q      (fld),
    .v_q      (vblank),
    .h_q      (hblank),
    .err_q    (hdr_err)
  );

  vid656_sample_path #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .word      (pix_in),
    .is_trs    (is_trs),
    .good_stb  (good_stb),
    .locked    (locked),
    .v_q       (vblank),
    .h_q       (hblank),
    .mode      (cap_mode_e'(cap_mode)),
    .drop_en   (drop_en),
    .keep_odd  (keep_odd),
    .sign_ext  (sign_ext),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

endmodule

// File: tb/tb_vid656_rx.sv
`timescale 1ns/1ps
module tb_vid656_rx;

  localparam int PIX_W = 10;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [PIX_W-1:0] pix_in;
  logic [1:0]       cap_mode;
  logic             drop_en, keep_odd, sign_ext;
  logic [OUT_W-1:0] out_data;
  logic             out_valid, fld, vblank, hblank, hdr_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // status vector table: {flip mask[7:0], f, v, h, correctable}
  localparam logic [11:0] VEC [0:13] = '{
    12'h001, 12'h00F, 12'h007, 12'h40B, 12'h205, 12'h10D, 12'h083,
    12'h049, 12'h027, 12'h01F, 12'h80B, 12'h300, 12'h0CC, 12'h506
  };

  vid656_rx #(.PIX_W(PIX_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .cap_mode(cap_mode),
    .drop_en(drop_en), .keep_odd(keep_odd), .sign_ext(sign_ext),
    .out_data(out_data), .out_valid(out_valid), .fld(fld),
    .vblank(vblank), .hblank(hblank), .hdr_err(hdr_err)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] mk(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present one word at a falling edge; returns at the next falling edge,
  // when the outputs reflect that word
  task automatic push(input logic [PIX_W-1:0] w);
    pix_in = w;
    @(negedge clk);
  endtask

  task automatic send_trs(input logic [7:0] hb, input bit quiet_chk);
    push('1);
    if (quiet_chk) chk("R5 ones word", {31'd0, out_valid}, 32'd0);
    push('0);
    if (quiet_chk) chk("R5 zero word", {31'd0, out_valid}, 32'd0);
    push('0);
    if (quiet_chk) chk("R5 zero word", {31'd0, out_valid}, 32'd0);
    push({hb, 2'b00});
    if (quiet_chk) chk("R5 status word", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pix_in = 10'h155;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [OUT_W-1:0] d);
    chk(tag, {31'd0, out_valid}, {31'd0, v});
    if (v) chk(tag, {16'd0, out_data}, {16'd0, d});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pix_in = '0; cap_mode = 2'd2;
    drop_en = 1'b0; keep_odd = 1'b0; sign_ext = 1'b0;
    @(negedge clk);

    // table of status words: clean, single-bit repaired, uncorrectable
    for (int i = 0; i < 14; i++) begin
      logic [7:0] msk;
      logic [2:0] fvh;
      logic       ok;
      string      tag;
      msk = VEC[i][11:4];
      fvh = VEC[i][3:1];
      ok  = VEC[i][0];
      tag = (msk == 8'h00) ? "R2 clean word" : (ok ? "R3 repaired word" : "R4 bad word");
      do_reset();
      send_trs(mk(1'b0, 1'b0, 1'b0), 1'b0);
      send_trs(mk(fvh[2], fvh[1], fvh[0]) ^ msk, 1'b0);
      chk(tag, {29'd0, fld, vblank, hblank}, {29'd0, (ok ? fvh : 3'b000)});
      chk(tag, {31'd0, hdr_err}, {31'd0, ~ok});
    end

    // R12 reset state
    rst = 1'b1;
    pix_in = 10'h155;
    @(negedge clk);
    chk("R12 reset in", {12'd0, out_valid, out_data, fld, vblank, hblank, hdr_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after reset", {12'd0, out_valid, out_data, fld, vblank, hblank, hdr_err}, 32'd0);

    // R9 nothing before the first accepted status word
    cap_mode = 2'd2;
    push(10'h155);
    expect_out("R9 unlocked", 1'b0, '0);

    // R1 status word after a full preamble loads the flags
    send_trs(mk(1'b1, 1'b0, 1'b0), 1'b0);
    chk("R1 flags", {29'd0, fld, vblank, hblank}, 32'd4);

    // R6 active region, R8 latency, R11 widening
    cap_mode = 2'd0;
    push(10'h204);
    expect_out("R6 active sample", 1'b1, 16'h0204);
    sign_ext = 1'b1;
    push(10'h204);
    expect_out("R11 sign extended", 1'b1, 16'hFE04);
    push(10'h1F0);
    expect_out("R11 positive sample", 1'b1, 16'h01F0);
    sign_ext = 1'b0;

    // R5 lone all-ones word dropped, following sample forwarded
    push('1);
    expect_out("R5 lone ones", 1'b0, '0);
    push(10'h123);
    expect_out("R5 after aborted preamble", 1'b1, 16'h0123);

    // end of active video: H=1
    send_trs(mk(1'b0, 1'b0, 1'b1), 1'b0);
    push(10'h111);
    expect_out("R6 horizontal blanking", 1'b0, '0);
    cap_mode = 2'd2;
    push(10'h222);
    expect_out("R8 whole field", 1'b1, 16'h0222);
    cap_mode = 2'd3;
    push(10'h233);
    expect_out("R9 mode off", 1'b0, '0);
    cap_mode = 2'd1;
    push(10'h244);
    expect_out("R7 not vertical blanking", 1'b0, '0);

    // vertical blanking line, H=0
    send_trs(mk(1'b0, 1'b1, 1'b0), 1'b0);
    push(10'h2AA);
    expect_out("R7 blanking sample", 1'b1, 16'h02AA);
    cap_mode = 2'd0;
    push(10'h2AB);
    expect_out("R6 outside active", 1'b0, '0);

    // R10 alternate-sample dropping, R5 silence while locked in whole field
    cap_mode = 2'd2;
    drop_en  = 1'b1;
    keep_odd = 1'b0;
    send_trs(mk(1'b0, 1'b0, 1'b0), 1'b1);
    push(10'h101); expect_out("R10 even idx0", 1'b1, 16'h0101);
    push(10'h102); expect_out("R10 even idx1", 1'b0, '0);
    push(10'h103); expect_out("R10 even idx2", 1'b1, 16'h0103);
    push(10'h104); expect_out("R10 even idx3", 1'b0, '0);
    keep_odd = 1'b1;
    send_trs(mk(1'b0, 1'b0, 1'b0), 1'b1);
    push(10'h105); expect_out("R10 odd idx0", 1'b0, '0);
    push(10'h106); expect_out("R10 odd idx1", 1'b1, 16'h0106);
    push(10'h107); expect_out("R10 odd idx2", 1'b0, '0);
    push(10'h108); expect_out("R10 odd idx3", 1'b1, 16'h0108);
    drop_en = 1'b0;

    // R4 sticky error survives later good words
    send_trs(mk(1'b0, 1'b0, 1'b0) ^ 8'h30, 1'b0);
    chk("R4 error raised", {31'd0, hdr_err}, 32'd1);
    send_trs(mk(1'b1, 1'b1, 1'b1), 1'b0);
    chk("R4 error held", {31'd0, hdr_err}, 32'd1);
    chk("R2 good word after error", {29'd0, fld, vblank, hblank}, 32'd7);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule